// File: doc/BRIEF.md
# Accumulator Round and Store Unit

This block turns a 40-bit signed accumulator value into one 16-bit 1.15 fixed-point word, ready to be written to data memory. It takes the high word (bits 31..16) as the result. The low word is either dropped (truncation) or used to round the high word. Two rounding modes are offered: conventional, which is biased, and convergent, which is unbiased. After rounding, an optional write-side saturation stage clamps any value that no longer fits in 1.15 to the largest positive or largest negative word.

A request is either a plain store or a write-back of the accumulator that the current operation does not target. A plain store is rounded only when asked and goes to an address given with the request. A write-back is always rounded. It uses an internal pointer register in one of two ways:
- In the indirect form, the word is written to the address held in the pointer, and the pointer then advances by 2.
- In the direct form, the word goes into the pointer register itself, and no memory write takes place.

The rounding and saturation path is combinational. The write strobe, data and address are registered, so they appear one clock after the request.

Top module: `acc_round_store`

## Requirements
- R1: While rst_ni is low, we_o, wdata_o, waddr_o and ptr_o are all 0.
- R2: With rnd_en_i=0 and wb_i=0, the stored word is accumulator bits 31..16, the low word 15..0 is discarded, and saturation (when enabled) is applied to that truncated value.
- R3: With rounding active and rnd_mode_i=0 (conventional), 1 is added to the sign-extended bits 39..16 exactly when accumulator bit 15 is 1.
- R4: With rounding active and rnd_mode_i=1 (convergent), the behaviour is as in R3, except when bits 15..0 equal 0x8000. In that case 1 is added only when bit 16 is 1.
- R5: With wb_i=1, rounding is applied whatever the value of rnd_en_i.
- R6: With sat_en_i=1, a rounded value above 32767 is stored as 0x7FFF and one below -32768 as 0x8000. A carry out of bit 31 from rounding counts, so 0x007FFF8000 rounded conventionally gives 0x7FFF.
- R7: With sat_en_i=0, the stored word is the low 16 bits of the rounded value (it wraps).
- R8: we_o pulses for one cycle, one clock after a request that writes memory. wdata_o and waddr_o change only with that pulse, and a plain store uses addr_i as its address.
- R9: An indirect write-back (wb_i=1, wb_direct_i=0) writes to the current pointer value, and the pointer then increases by 2 (modulo 2^ADDR_W).
- R10: A direct write-back (wb_i=1, wb_direct_i=1) raises no strobe, leaves wdata_o and waddr_o unchanged, and loads the word into the pointer one clock later.
- R11: ptr_load_i loads ptr_val_i into the pointer when no request is present. It is ignored in a cycle with req_i=1, and otherwise the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Store or write-back request |
| acc_i | input | 40 | Accumulator value to convert |
| rnd_en_i | input | 1 | Round instead of truncate (plain store) |
| rnd_mode_i | input | 1 | 0 conventional, 1 convergent |
| sat_en_i | input | 1 | Enable write-data saturation |
| wb_i | input | 1 | Request is a non-target write-back |
| wb_direct_i | input | 1 | Write-back goes into the pointer register |
| addr_i | input | 16 | Address for a plain store |
| ptr_load_i | input | 1 | Load the pointer register |
| ptr_val_i | input | 16 | Value for a pointer load |
| we_o | output | 1 | Memory write strobe |
| wdata_o | output | 16 | 1.15 write data |
| waddr_o | output | 16 | Write address |
| ptr_o | output | 16 | Pointer register value |

## Verification
The hardest case to reach from the ports is a convergent tie that also carries out of bit 31 into saturation. This needs a low word of exactly 0x8000, bit 16 set, and a high word of 0x7FFF with zero guard bits, all at once. Its mirror case, with bit 16 clear, must not round up. Directed vectors cover both, along with the same patterns near the negative limit. Random stimulus then draws its low words mostly from the tie and near-tie values and its upper bits from the boundary region, so that all modes meet those points again. Pointer loads collide with requests at random to exercise the priority rule.

// File: rtl/acc_rs_pkg.sv
package acc_rs_pkg;
  typedef enum logic {
    RND_BIASED    = 1'b0,
    RND_UNBIASED  = 1'b1
  } rnd_mode_e;

  typedef enum logic [1:0] {
    OP_STORE   = 2'd0,
    OP_WB_IND  = 2'd1,
    OP_WB_DIR  = 2'd2
  } op_kind_e;
endpackage

// File: rtl/acc_rnd_core.sv
module acc_rnd_core #(
  parameter int ACC_W  = 40,
  parameter int FRAC_W = 16,
  localparam int UP_W  = ACC_W - FRAC_W,
  localparam int SUM_W = UP_W + 1
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             rnd_i,
  input  logic             mode_i,
  output logic [SUM_W-1:0] val_o
);
  import acc_rs_pkg::*;

  logic half, below_rest, lsb, inc;

  assign half       = acc_i[FRAC_W-1];
  assign below_rest = |acc_i[FRAC_W-2:0];
  assign lsb        = acc_i[FRAC_W];

  always_comb begin
    inc = 1'b0;
    if (rnd_i) begin
      if (mode_i == RND_UNBIASED) inc = half & (below_rest | lsb);
      else                        inc = half;
    end
  end

  // one extra bit keeps the carry out of the top
  assign val_o = {acc_i[ACC_W-1], acc_i[ACC_W-1:FRAC_W]} + SUM_W'(inc);
endmodule

// File: rtl/acc_sat_clamp.sv
module acc_sat_clamp #(
  parameter int IN_W   = 25,
  parameter int DATA_W = 16,
  localparam int TOP_W = IN_W - DATA_W + 1
) (
  input  logic [IN_W-1:0]   val_i,
  input  logic              sat_en_i,
  output logic              ovf_o,
  output logic [DATA_W-1:0] word_o
);
  logic [TOP_W-1:0] top;

  assign top   = val_i[IN_W-1:DATA_W-1];
  assign ovf_o = !((top == '0) || (top == '1));

  always_comb begin
    word_o = val_i[DATA_W-1:0];
    if (sat_en_i && ovf_o)
      word_o = val_i[IN_W-1] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
  end
endmodule

// File: rtl/acc_wb_ptr.sv
module acc_wb_ptr #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int STEP   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  output logic [ADDR_W-1:0] ptr_o
);
  import acc_rs_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
    end else if (req_i) begin
      if (op_i == OP_WB_IND)      ptr_o <= ptr_o + ADDR_W'(STEP);
      else if (op_i == OP_WB_DIR) ptr_o <= ADDR_W'(word_i);
    end else if (load_i) begin
      ptr_o <= load_val_i;
    end
  end

  // R9
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == OP_WB_IND) |=> ptr_o == $past(ptr_o) + ADDR_W'(STEP));

  // R11
  ptr_load_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == OP_STORE) |=> $stable(ptr_o));
endmodule

// File: rtl/acc_round_store.sv
module acc_round_store #(
  parameter int ACC_W  = 40,
  parameter int DATA_W = 16,
  parameter int FRAC_W = 16,
  parameter int ADDR_W = 16,
  localparam int SUM_W = ACC_W - FRAC_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic              rnd_en_i,
  input  logic              rnd_mode_i,
  input  logic              sat_en_i,
  input  logic              wb_i,
  input  logic              wb_direct_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ptr_load_i,
  input  logic [ADDR_W-1:0] ptr_val_i,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W-1:0] ptr_o
);
  import acc_rs_pkg::*;

  logic [SUM_W-1:0]  rnd_val;
  logic [DATA_W-1:0] sat_word;
  logic              ovf;
  logic [1:0]        op;
  logic              mem_wr;

  always_comb begin
    if (!wb_i)            op = OP_STORE;
    else if (wb_direct_i) op = OP_WB_DIR;
    else                  op = OP_WB_IND;
  end

  assign mem_wr = req_i && (op != OP_WB_DIR);

  acc_rnd_core #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_rnd (
    .acc_i (acc_i),
    .rnd_i (rnd_en_i | wb_i),
    .mode_i(rnd_mode_i),
    .val_o (rnd_val)
  );

  acc_sat_clamp #(.IN_W(SUM_W), .DATA_W(DATA_W)) u_sat (
    .val_i   (rnd_val),
    .sat_en_i(sat_en_i),
    .ovf_o   (ovf),
    .word_o  (sat_word)
  );

  acc_wb_ptr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP(2)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .op_i      (op),
    .word_i    (sat_word),
    .load_i    (ptr_load_i),
    .load_val_i(ptr_val_i),
    .ptr_o     (ptr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      wdata_o <= '0;
      waddr_o <= '0;
    end else begin
      we_o <= mem_wr;
      if (mem_wr) begin
        wdata_o <= sat_word;
        waddr_o <= (op == OP_WB_IND) ? ptr_o : addr_i;
      end
    end
  end

  // R8
  strobe_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !(wb_i && wb_direct_i)) |=> !we_o);

  // R10
  direct_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wb_i && wb_direct_i) |=> (!we_o && $stable(wdata_o) && $stable(waddr_o)));

  // R9
  ind_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wb_i && !wb_direct_i) |=> (we_o && waddr_o == $past(ptr_o)));

  // R6
  sat_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_en_i && ovf) |-> (sat_word == {1'b0, {(DATA_W-1){1'b1}}} ||
                           sat_word == {1'b1, {(DATA_W-1){1'b0}}}));

  // R2
  trunc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !rnd_en_i && !wb_i && !sat_en_i) |=> wdata_o == $past(acc_i[FRAC_W+DATA_W-1:FRAC_W]));
endmodule

// File: tb/sim_acc_round_store.sv
module sim_acc_round_store;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 0, rnd_en_i = 0, rnd_mode_i = 0, sat_en_i = 0, wb_i = 0, wb_direct_i = 0, ptr_load_i = 0;
  logic [39:0] acc_i = '0;
  logic [15:0] addr_i = '0, ptr_val_i = '0;
  logic        we_o;
  logic [15:0] wdata_o, waddr_o, ptr_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic        m_we = 0;
  logic [15:0] m_wdata = 0, m_waddr = 0, m_ptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_round_store u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .acc_i(acc_i),
    .rnd_en_i(rnd_en_i), .rnd_mode_i(rnd_mode_i), .sat_en_i(sat_en_i),
    .wb_i(wb_i), .wb_direct_i(wb_direct_i), .addr_i(addr_i),
    .ptr_load_i(ptr_load_i), .ptr_val_i(ptr_val_i),
    .we_o(we_o), .wdata_o(wdata_o), .waddr_o(waddr_o), .ptr_o(ptr_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // reference word, returns tag of the rule that decided it
  function automatic logic [15:0] ref_word(input logic [39:0] a, input bit rnd, input bit conv,
                                           input bit sat, input bit wb, output string tag);
    longint v, hi, lo, r;
    bit     inc;
    v  = longint'($signed(a));
    hi = v >>> 16;
    lo = v & 64'hFFFF;
    inc = 0;
    if (rnd) begin
      if (lo > 32768) inc = 1;
      else if (lo == 32768) inc = conv ? bit'(hi & 1) : 1'b1;
    end
    r = hi + longint'(inc);
    if (r > 32767 || r < -32768) tag = sat ? "R6" : "R7";
    else if (wb && !rnd_en_i) tag = "R5";
    else if (!rnd) tag = "R2";
    else if (conv) tag = "R4";
    else tag = "R3";
    if (sat && r > 32767)       return 16'h7FFF;
    else if (sat && r < -32768) return 16'h8000;
    else                        return r[15:0];
  endfunction

  // advance one clock: model the edge just passed, then compare
  task automatic step();
    string tag, ptag;
    logic [15:0] w;
    bit mem;
    @(negedge clk);
    w   = ref_word(acc_i, rnd_en_i | wb_i, rnd_mode_i, sat_en_i, wb_i, tag);
    mem = req_i && !(wb_i && wb_direct_i);
    m_we = mem;
    if (mem) begin
      m_wdata = w;
      m_waddr = wb_i ? m_ptr : addr_i;
    end
    if (req_i && wb_i && wb_direct_i) begin
      m_ptr = w; ptag = "R10";
    end else if (req_i && wb_i) begin
      m_ptr = m_ptr + 16'd2; ptag = "R9";
    end else begin
      if (!req_i && ptr_load_i) m_ptr = ptr_val_i;
      ptag = "R11";
    end
    #1;
    chk((req_i && wb_i && wb_direct_i) ? "R10 strobe" : "R8 strobe", we_o, m_we);
    chk(mem ? tag : "R8 hold data", wdata_o, m_wdata);
    chk((req_i && wb_i) ? "R9 addr" : "R8 addr", waddr_o, m_waddr);
    chk(ptag, ptr_o, m_ptr);
  endtask

  task automatic drive(input bit rq, input logic [39:0] a, input bit re, input bit md, input bit se,
                       input bit wb, input bit dir, input logic [15:0] ad, input bit ld, input logic [15:0] lv);
    req_i = rq; acc_i = a; rnd_en_i = re; rnd_mode_i = md; sat_en_i = se;
    wb_i = wb; wb_direct_i = dir; addr_i = ad; ptr_load_i = ld; ptr_val_i = lv;
  endtask

  function automatic logic [39:0] pick_acc();
    logic [15:0] lo;
    logic [23:0] up;
    case ($urandom_range(0, 4))
      0: lo = 16'h8000;
      1: lo = 16'h7FFF;
      2: lo = 16'h8001;
      3: lo = 16'hFFFF;
      default: lo = 16'($urandom);
    endcase
    case ($urandom_range(0, 5))
      0: up = 24'h007FFF;
      1: up = 24'hFF8000;
      2: up = 24'h007FFE;
      3: up = 24'hFFFFFF;
      4: up = 24'($urandom);
      default: up = {{8{1'b0}}, 16'($urandom)} ^ {24{$urandom_range(0, 1) == 1}};
    endcase
    return {up, lo};
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset values
    chk("R1 we", we_o, 0);
    chk("R1 wdata", wdata_o, 0);
    chk("R1 waddr", waddr_o, 0);
    chk("R1 ptr", ptr_o, 0);
    rst_ni = 1'b1;

    // R2 truncation
    drive(1, 40'h00_1234_FFFF, 0, 0, 0, 0, 0, 16'h0100, 0, 0); step();
    // R3 conventional up / not up
    drive(1, 40'h00_1234_8000, 1, 0, 0, 0, 0, 16'h0102, 0, 0); step();
    drive(1, 40'h00_1234_7FFF, 1, 0, 0, 0, 0, 16'h0104, 0, 0); step();
    // R4 convergent ties
    drive(1, 40'h00_1234_8000, 1, 1, 0, 0, 0, 16'h0106, 0, 0); step();
    drive(1, 40'h00_1235_8000, 1, 1, 0, 0, 0, 16'h0108, 0, 0); step();
    drive(1, 40'h00_1234_8001, 1, 1, 0, 0, 0, 16'h010A, 0, 0); step();
    // R6 carry into saturation, convergent tie mirror pair
    drive(1, 40'h00_7FFF_8000, 1, 0, 1, 0, 0, 16'h010C, 0, 0); step();
    drive(1, 40'h00_7FFF_8000, 1, 1, 1, 0, 0, 16'h010E, 0, 0); step();
    drive(1, 40'h00_7FFE_8000, 1, 1, 1, 0, 0, 16'h0110, 0, 0); step();
    drive(1, 40'hFF_7FFF_0000, 0, 0, 1, 0, 0, 16'h0112, 0, 0); step();
    // R7 wrap without saturation
    drive(1, 40'h00_7FFF_8000, 1, 0, 0, 0, 0, 16'h0114, 0, 0); step();
    // R11 load, then load colliding with a store
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h2000); step();
    drive(1, 40'h00_0001_0000, 0, 0, 0, 0, 0, 16'h0116, 1, 16'h3000); step();
    // R9 and R5 indirect write-back, rounding without rnd_en_i
    drive(1, 40'h00_0042_8000, 0, 0, 0, 1, 0, 0, 0, 0); step();
    drive(1, 40'h00_0042_8000, 0, 1, 0, 1, 0, 0, 0, 0); step();
    // R10 direct write-back
    drive(1, 40'h00_4321_C000, 0, 0, 0, 1, 1, 0, 0, 0); step();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); step();

    for (int i = 0; i < 4000; i++) begin
      bit rq, wb;
      rq = $urandom_range(0, 3) != 0;
      wb = $urandom_range(0, 2) == 0;
      drive(rq, pick_acc(), 1'($urandom), 1'($urandom), 1'($urandom), wb, 1'($urandom),
            16'($urandom), $urandom_range(0, 7) == 0, 16'($urandom));
      step();
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); step();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule